// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recent translations from a 20-bit virtual page number to a page-table entry. The entry holds a frame number, two protection bits and a dirty bit. A lookup compares the page number against every resident entry at once; there is no index or set selection. On a hit, the frame, the status bits and the physical address (frame joined to the 12-bit page offset) come back combinationally in the same cycle. On a miss the block raises a walk request. The walker later presents the entry on the fill inputs, and the block installs it.

When no slot is free, a victim is chosen. The policy is fixed at elaboration: least recently used, or pseudo-random from a free-running LFSR. Software can drop one translation by page number, or drop all of them at once on a context switch. A dirty entry that leaves the buffer, whether evicted, invalidated or flushed, is presented on a write-back port so that the page table can record the modified state.

Top module: `vpn_xlat_buf`

## Requirements
- R1: A lookup hit returns, in the same cycle, the stored frame number, protection bits and dirty bit. `paddr_o` equals the frame number in bits 31:12 and the lookup offset in bits 11:0.
- R2: Any cycle with a lookup that misses asserts `walk_req_o` in that cycle. On a miss, `hit_o`, `pfn_o` and `paddr_o` are zero, and `walk_req_o` is low when no lookup is presented. After reset, every lookup misses and `wb_en_o` is low.
- R3: A fill installs its entry, and a lookup of that page hits from the next cycle on. While any slot is free, the fill takes the lowest-numbered free slot.
- R4: With the least-recently-used policy and no free slot, the fill evicts the valid entry touched least recently. A touch is a hit whose state update is applied, or a fill. Among entries touched in the same cycle, the lowest index is evicted first.
- R5: With the random policy and no free slot, a fill displaces exactly one resident entry. When a slot is free, no resident entry is displaced.
- R6: A write lookup (`lkp_we_i` = 1) that hits sets the stored dirty bit, which is reported on later hits. A read hit leaves it unchanged. `dirty_o` shows the value held before the access.
- R7: Evicting a dirty entry drives `wb_en_o` high for one cycle after the fill edge, carrying the evicted page, frame and protection bits. Evicting a clean entry produces no write-back.
- R8: An invalidate makes the matching entry miss from the next cycle on. If that entry was dirty, it is written back in the cycle after the invalidate edge. An invalidate naming a non-resident page has no effect.
- R9: A flush empties the buffer from the next cycle on. The entries that were dirty are written back one per cycle, lowest index first, starting one cycle later than an invalidate write-back would appear. Clean entries are not written back.
- R10: A flush takes priority over everything else in its cycle. A lookup in that cycle reports a miss, and a fill or invalidate in that cycle is ignored.
- R11: An invalidate takes priority over a fill in the same cycle, and that fill is dropped. In an invalidate cycle, a lookup still reports its hit, but it neither refreshes recency nor sets the dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_en_i | input | 1 | Lookup request |
| lkp_we_i | input | 1 | Lookup is a write access |
| lkp_vpn_i | input | 20 | Lookup virtual page number |
| lkp_ofs_i | input | 12 | Lookup page offset |
| hit_o | output | 1 | Lookup hit |
| walk_req_o | output | 1 | Lookup missed; walk needed |
| pfn_o | output | 20 | Frame number on hit |
| prot_o | output | 2 | Protection bits on hit |
| dirty_o | output | 1 | Stored dirty bit on hit |
| paddr_o | output | 32 | Physical address on hit |
| fill_en_i | input | 1 | Install walker result |
| fill_vpn_i | input | 20 | Page number to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_prot_i | input | 2 | Protection bits to install |
| fill_dirty_i | input | 1 | Dirty bit to install |
| inv_en_i | input | 1 | Invalidate one entry |
| inv_vpn_i | input | 20 | Page number to invalidate |
| flush_i | input | 1 | Invalidate all entries |
| wb_en_o | output | 1 | Write-back of a dirty entry |
| wb_vpn_o | output | 20 | Write-back page number |
| wb_pfn_o | output | 20 | Write-back frame number |
| wb_prot_o | output | 2 | Write-back protection bits |

## Verification
Hit, walk request, frame, status and physical address are combinational in the lookup cycle. The bench drives every input on the falling edge and samples these outputs one time unit later, before the next rising edge. Fill, invalidate, flush and dirty updates take effect at the rising edge, so the next cycle's lookup is what shows them. The write-back port is registered: eviction and invalidate write-backs are checked one time unit after the edge that performed them. Flush write-backs are checked on each of the following edges, in the order a reference model predicts from the drain rules.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int OFS_W  = 12;
  localparam int PROT_W = 2;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PROT_W-1:0] prot;
    logic              dirty;
  } xlat_ent_t;
endpackage

// File: rtl/xlat_prio.sv
// lowest-index-first priority encoder
module xlat_prio #(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter  int N     = 8,
  parameter  int KEY_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]        key_i,
  output logic [N-1:0]            match_o,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (keys_i[g] == key_i);
  end

  xlat_prio #(.N(N)) u_enc (
    .req_i (match_o),
    .any_o (any_o),
    .idx_o (idx_o)
  );
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter  int N       = 8,
  parameter  bit USE_LRU = 1'b1,
  parameter  int AGE_W   = 16,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     free_i,
  input  logic [N-1:0]     touch_i,
  output logic [IDX_W-1:0] victim_o
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] pol_idx;

  xlat_prio #(.N(N)) u_free (
    .req_i (free_i),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  if (USE_LRU) begin : g_lru
    logic [N-1:0][AGE_W-1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q <= '0;
      end else if (|touch_i) begin
        for (int i = 0; i < N; i++) begin
          if (touch_i[i])         age_q[i] <= '0;
          else if (~&age_q[i])    age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end

    // oldest wins, strict compare keeps the lowest index on ties
    always_comb begin
      pol_idx = '0;
      for (int i = 1; i < N; i++) begin
        if (age_q[i] > age_q[pol_idx]) pol_idx = IDX_W'(i);
      end
    end
  end else begin : g_rnd
    logic [15:0] lfsr_q;
    logic        touch_unused;

    assign touch_unused = ^touch_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lfsr_q <= 16'hACE1;
      else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    assign pol_idx = IDX_W'(lfsr_q % 16'(N));
  end

  assign victim_o = free_any ? free_idx : pol_idx;
endmodule

// File: rtl/vpn_xlat_buf.sv
module vpn_xlat_buf
  import xlat_pkg::*;
#(
  parameter  int ENTRIES = 8,
  parameter  bit USE_LRU = 1'b1,
  parameter  int AGE_W   = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lkp_en_i,
  input  logic                    lkp_we_i,
  input  logic [VPN_W-1:0]        lkp_vpn_i,
  input  logic [OFS_W-1:0]        lkp_ofs_i,
  output logic                    hit_o,
  output logic                    walk_req_o,
  output logic [PFN_W-1:0]        pfn_o,
  output logic [PROT_W-1:0]       prot_o,
  output logic                    dirty_o,
  output logic [PFN_W+OFS_W-1:0]  paddr_o,
  input  logic                    fill_en_i,
  input  logic [VPN_W-1:0]        fill_vpn_i,
  input  logic [PFN_W-1:0]        fill_pfn_i,
  input  logic [PROT_W-1:0]       fill_prot_i,
  input  logic                    fill_dirty_i,
  input  logic                    inv_en_i,
  input  logic [VPN_W-1:0]        inv_vpn_i,
  input  logic                    flush_i,
  output logic                    wb_en_o,
  output logic [VPN_W-1:0]        wb_vpn_o,
  output logic [PFN_W-1:0]        wb_pfn_o,
  output logic [PROT_W-1:0]       wb_prot_o
);
  xlat_ent_t [ENTRIES-1:0]            ent_q;
  logic [ENTRIES-1:0]                 valid_q, pend_q;
  logic [ENTRIES-1:0][VPN_W-1:0]      vpn_all;

  logic [ENTRIES-1:0] lkp_match, inv_match_unused, free, touch, vic_oh;
  logic               lkp_any, inv_any, drn_any;
  logic [IDX_W-1:0]   lkp_idx, inv_idx, victim, drn_idx;
  logic               hit, upd_act, inv_act, fill_act;
  logic               evict_wb, inv_wb, drn_take;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_keys
    assign vpn_all[g] = ent_q[g].vpn;
  end

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_lkp (
    .valid_i (valid_q),
    .keys_i  (vpn_all),
    .key_i   (lkp_vpn_i),
    .match_o (lkp_match),
    .any_o   (lkp_any),
    .idx_o   (lkp_idx)
  );

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_inv (
    .valid_i (valid_q),
    .keys_i  (vpn_all),
    .key_i   (inv_vpn_i),
    .match_o (inv_match_unused),
    .any_o   (inv_any),
    .idx_o   (inv_idx)
  );

  // lookup result: flush masks every hit
  assign hit        = lkp_en_i && !flush_i && lkp_any;
  assign hit_o      = hit;
  assign walk_req_o = lkp_en_i && !hit;
  assign pfn_o      = hit ? ent_q[lkp_idx].pfn   : '0;
  assign prot_o     = hit ? ent_q[lkp_idx].prot  : '0;
  assign dirty_o    = hit ? ent_q[lkp_idx].dirty : 1'b0;
  assign paddr_o    = hit ? {ent_q[lkp_idx].pfn, lkp_ofs_i} : '0;

  // priority: flush > invalidate > fill
  assign inv_act  = inv_en_i && !flush_i && inv_any;
  assign fill_act = fill_en_i && !flush_i && !inv_en_i;
  assign upd_act  = hit && !inv_en_i;

  assign free   = ~valid_q & ~pend_q;
  assign vic_oh = ENTRIES'(1) << victim;
  assign touch  = (upd_act ? lkp_match : '0) | (fill_act ? vic_oh : '0);

  xlat_victim #(.N(ENTRIES), .USE_LRU(USE_LRU), .AGE_W(AGE_W)) u_vic (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .free_i   (free),
    .touch_i  (touch),
    .victim_o (victim)
  );

  // flushed dirty entries wait in pend_q and drain one per cycle
  xlat_prio #(.N(ENTRIES)) u_drain (
    .req_i (pend_q),
    .any_o (drn_any),
    .idx_o (drn_idx)
  );

  assign evict_wb = fill_act && ((valid_q[victim] && ent_q[victim].dirty) || pend_q[victim]);
  assign inv_wb   = inv_act && ent_q[inv_idx].dirty;
  assign drn_take = drn_any && !evict_wb && !inv_wb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q   <= '0;
      valid_q <= '0;
      pend_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_i) begin
          valid_q[i] <= 1'b0;
          pend_q[i]  <= (pend_q[i] && !(drn_take && drn_idx == IDX_W'(i)))
                        || (valid_q[i] && ent_q[i].dirty);
        end else begin
          if (drn_take && drn_idx == IDX_W'(i)) pend_q[i] <= 1'b0;
          if (inv_act && inv_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
          if (upd_act && lkp_we_i && lkp_idx == IDX_W'(i)) ent_q[i].dirty <= 1'b1;
          if (fill_act && victim == IDX_W'(i)) begin
            valid_q[i] <= 1'b1;
            pend_q[i]  <= 1'b0;
            ent_q[i]   <= '{vpn: fill_vpn_i, pfn: fill_pfn_i, prot: fill_prot_i, dirty: fill_dirty_i};
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_vpn_o  <= '0;
      wb_pfn_o  <= '0;
      wb_prot_o <= '0;
    end else begin
      wb_en_o <= evict_wb || inv_wb || drn_take;
      if (evict_wb) begin
        wb_vpn_o  <= ent_q[victim].vpn;
        wb_pfn_o  <= ent_q[victim].pfn;
        wb_prot_o <= ent_q[victim].prot;
      end else if (inv_wb) begin
        wb_vpn_o  <= ent_q[inv_idx].vpn;
        wb_pfn_o  <= ent_q[inv_idx].pfn;
        wb_prot_o <= ent_q[inv_idx].prot;
      end else if (drn_take) begin
        wb_vpn_o  <= ent_q[drn_idx].vpn;
        wb_pfn_o  <= ent_q[drn_idx].pfn;
        wb_prot_o <= ent_q[drn_idx].prot;
      end
    end
  end
endmodule

// File: rtl/vpn_xlat_buf_chk.sv
module vpn_xlat_buf_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_en_i,
  input logic [VPN_W-1:0] lkp_vpn_i,
  input logic             hit_o,
  input logic             walk_req_o,
  input logic             fill_en_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic             inv_en_i,
  input logic [VPN_W-1:0] inv_vpn_i,
  input logic             flush_i
);
  p_walk_on_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_en_i && !hit_o) |-> walk_req_o);

  p_no_walk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lkp_en_i || hit_o) |-> !walk_req_o);

  p_fill_visible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !flush_i && !inv_en_i) |=>
      ((lkp_en_i && !flush_i && lkp_vpn_i == $past(fill_vpn_i)) -> hit_o));

  p_inv_gone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_en_i && !flush_i) |=>
      ((lkp_en_i && lkp_vpn_i == $past(inv_vpn_i)) -> !hit_o));

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  p_flush_miss_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !hit_o);
endmodule

bind vpn_xlat_buf vpn_xlat_buf_chk #(.VPN_W(xlat_pkg::VPN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lkp_en_i   (lkp_en_i),
  .lkp_vpn_i  (lkp_vpn_i),
  .hit_o      (hit_o),
  .walk_req_o (walk_req_o),
  .fill_en_i  (fill_en_i),
  .fill_vpn_i (fill_vpn_i),
  .inv_en_i   (inv_en_i),
  .inv_vpn_i  (inv_vpn_i),
  .flush_i    (flush_i)
);

// File: tb/vpn_xlat_buf_bench.sv
module vpn_xlat_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // LRU instance
  logic        lkp_en, lkp_we, fill_en, fill_dirty, inv_en, flush;
  logic [19:0] lkp_vpn, fill_vpn, fill_pfn, inv_vpn;
  logic [11:0] lkp_ofs;
  logic [1:0]  fill_prot;
  logic        hit, walk, dirty_o, wb_en;
  logic [19:0] pfn, wb_vpn, wb_pfn;
  logic [1:0]  prot, wb_prot;
  logic [31:0] paddr;

  vpn_xlat_buf #(.ENTRIES(N), .USE_LRU(1'b1)) u_vpn_xlat_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_en_i(lkp_en), .lkp_we_i(lkp_we), .lkp_vpn_i(lkp_vpn), .lkp_ofs_i(lkp_ofs),
    .hit_o(hit), .walk_req_o(walk), .pfn_o(pfn), .prot_o(prot), .dirty_o(dirty_o), .paddr_o(paddr),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_prot_i(fill_prot),
    .fill_dirty_i(fill_dirty), .inv_en_i(inv_en), .inv_vpn_i(inv_vpn), .flush_i(flush),
    .wb_en_o(wb_en), .wb_vpn_o(wb_vpn), .wb_pfn_o(wb_pfn), .wb_prot_o(wb_prot)
  );

  // random-policy instance
  logic        r_lkp_en, r_fill_en, r_inv_en;
  logic [19:0] r_lkp_vpn, r_fill_vpn, r_fill_pfn, r_inv_vpn;
  logic        r_hit, r_walk, r_dirty, r_wb_en;
  logic [19:0] r_pfn, r_wb_vpn, r_wb_pfn;
  logic [1:0]  r_prot, r_wb_prot;
  logic [31:0] r_paddr;

  vpn_xlat_buf #(.ENTRIES(N), .USE_LRU(1'b0)) u_rnd (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_en_i(r_lkp_en), .lkp_we_i(1'b0), .lkp_vpn_i(r_lkp_vpn), .lkp_ofs_i(12'h0),
    .hit_o(r_hit), .walk_req_o(r_walk), .pfn_o(r_pfn), .prot_o(r_prot), .dirty_o(r_dirty), .paddr_o(r_paddr),
    .fill_en_i(r_fill_en), .fill_vpn_i(r_fill_vpn), .fill_pfn_i(r_fill_pfn), .fill_prot_i(2'b00),
    .fill_dirty_i(1'b0), .inv_en_i(r_inv_en), .inv_vpn_i(r_inv_vpn), .flush_i(1'b0),
    .wb_en_o(r_wb_en), .wb_vpn_o(r_wb_vpn), .wb_pfn_o(r_wb_pfn), .wb_prot_o(r_wb_prot)
  );

  // reference model
  logic        m_valid [N];
  logic        m_pend  [N];
  logic        m_dirty [N];
  logic [19:0] m_vpn   [N];
  logic [19:0] m_pfn   [N];
  logic [1:0]  m_prot  [N];
  int          m_stamp [N];
  int          tick = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    int b;
    for (int i = 0; i < N; i++) if (!m_valid[i] && !m_pend[i]) return i;
    b = 0;
    for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[b]) b = i;
    return b;
  endfunction

  task automatic cyc(input string tag, input bit le, input bit we, input logic [19:0] lv,
                     input logic [11:0] lo, input bit fe, input logic [19:0] fv,
                     input logic [19:0] fp, input logic [1:0] fpr, input bit fd,
                     input bit ie, input logic [19:0] iv, input bit fl);
    int h, ii, v, src;
    bit eh, ia, fa, upd, ew;
    logic [19:0] evp, epf;
    logic [1:0]  epr;
    string wtag;
    @(negedge clk);
    lkp_en = le; lkp_we = we; lkp_vpn = lv; lkp_ofs = lo;
    fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_prot = fpr; fill_dirty = fd;
    inv_en = ie; inv_vpn = iv; flush = fl;
    #1;
    h  = (le && !fl) ? find(lv) : -1;
    eh = (h >= 0);
    check(hit == eh, tag, "hit", 64'(hit), 64'(eh));
    check(walk == (le && !eh), tag, "walk_req", 64'(walk), 64'(le && !eh));
    if (eh) begin
      check(pfn == m_pfn[h] && prot == m_prot[h] && dirty_o == m_dirty[h], tag, "pfn/prot/dirty",
            {41'd0, pfn, prot, dirty_o}, {41'd0, m_pfn[h], m_prot[h], m_dirty[h]});
      check(paddr == {m_pfn[h], lo}, tag, "paddr", 64'(paddr), 64'({m_pfn[h], lo}));
    end else begin
      check(pfn == 20'd0 && paddr == 32'd0, tag, "miss outputs", 64'(paddr), 64'd0);
    end
    ii  = find(iv);
    ia  = ie && !fl && (ii >= 0);
    fa  = fe && !fl && !ie;
    upd = eh && !ie;
    v   = fa ? pick_victim() : -1;
    ew = 1'b0; src = -1; wtag = tag;
    if (fa && ((m_valid[v] && m_dirty[v]) || m_pend[v])) begin
      ew = 1'b1; src = v; wtag = "R7";
    end else if (ia && m_dirty[ii]) begin
      ew = 1'b1; src = ii; wtag = "R8";
    end else begin
      for (int i = 0; i < N; i++) if (!ew && m_pend[i]) begin
        ew = 1'b1; src = i; wtag = "R9";
      end
      if (ew) m_pend[src] = 1'b0;
    end
    if (ew) begin evp = m_vpn[src]; epf = m_pfn[src]; epr = m_prot[src]; end
    else begin evp = '0; epf = '0; epr = '0; end
    if (upd || fa) tick++;
    if (fl) begin
      for (int i = 0; i < N; i++) begin
        if (m_valid[i] && m_dirty[i]) m_pend[i] = 1'b1;
        m_valid[i] = 1'b0;
      end
    end else begin
      if (ia) m_valid[ii] = 1'b0;
      if (upd) begin
        m_stamp[h] = tick;
        if (we) m_dirty[h] = 1'b1;
      end
      if (fa) begin
        m_valid[v] = 1'b1; m_pend[v] = 1'b0; m_vpn[v] = fv; m_pfn[v] = fp;
        m_prot[v] = fpr; m_dirty[v] = fd; m_stamp[v] = tick;
      end
    end
    @(posedge clk);
    #1;
    check(wb_en == ew, wtag, "wb_en", 64'(wb_en), 64'(ew));
    if (ew) check(wb_vpn == evp && wb_pfn == epf && wb_prot == epr, wtag, "wb data",
                  {22'd0, wb_vpn, wb_pfn, wb_prot}, {22'd0, evp, epf, epr});
  endtask

  task automatic look(input string tag, input logic [19:0] v, input bit we);
    cyc(tag, 1'b1, we, v, 12'hA5C, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic fill(input string tag, input logic [19:0] v, input logic [19:0] p, input bit d);
    cyc(tag, 1'b0, 1'b0, '0, '0, 1'b1, v, p, 2'(v), d, 1'b0, '0, 1'b0);
  endtask

  task automatic rcyc(input bit le, input logic [19:0] lv, input bit fe, input logic [19:0] fv,
                      input bit ie, input logic [19:0] iv);
    @(negedge clk);
    r_lkp_en = le; r_lkp_vpn = lv; r_fill_en = fe; r_fill_vpn = fv;
    r_fill_pfn = fv ^ 20'h5A5A5; r_inv_en = ie; r_inv_vpn = iv;
    #1;
  endtask

  function automatic logic [19:0] pool(input int i);
    return 20'(32'h3C000 + i * 32'h1357);
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hits, cool, r;
    bit fl, ie, fe, le, we;
    logic [19:0] fv, iv, lv;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_pend[i] = 0; m_dirty[i] = 0; m_vpn[i] = 0;
      m_pfn[i] = 0; m_prot[i] = 0; m_stamp[i] = 0;
    end
    lkp_en = 0; lkp_we = 0; lkp_vpn = 0; lkp_ofs = 0; fill_en = 0; fill_vpn = 0;
    fill_pfn = 0; fill_prot = 0; fill_dirty = 0; inv_en = 0; inv_vpn = 0; flush = 0;
    r_lkp_en = 0; r_lkp_vpn = 0; r_fill_en = 0; r_fill_vpn = 0; r_fill_pfn = 0;
    r_inv_en = 0; r_inv_vpn = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    check(wb_en == 1'b0, "R2", "wb_en after reset", 64'(wb_en), 64'd0);
    look("R2", 20'h00001, 1'b0);

    // R3, R1: fills take lowest free slots, hits return contents
    fill("R3", 20'h00A00, 20'h11111, 1'b0);
    fill("R3", 20'h00B00, 20'h22222, 1'b0);
    fill("R3", 20'h00C00, 20'h33333, 1'b0);
    look("R1", 20'h00A00, 1'b0);
    look("R1", 20'h00C00, 1'b0);
    look("R2", 20'h00D00, 1'b0);

    // R6: write hit sets dirty, read hit does not
    look("R6", 20'h00B00, 1'b0);
    look("R6", 20'h00B00, 1'b0);
    look("R6", 20'h00A00, 1'b1);
    look("R6", 20'h00A00, 1'b0);

    // fill to full; slot 3 dirty and oldest after touches
    fill("R3", 20'h00D00, 20'h44444, 1'b1);
    fill("R3", 20'h00E00, 20'h55555, 1'b0);
    fill("R3", 20'h00F00, 20'h66666, 1'b0);
    fill("R3", 20'h01000, 20'h77777, 1'b1);
    fill("R3", 20'h01100, 20'h88888, 1'b0);
    look("R4", 20'h00A00, 1'b0);
    look("R4", 20'h00B00, 1'b0);
    look("R4", 20'h00C00, 1'b0);
    // R4, R7: LRU victim is dirty entry, then a clean one
    fill("R4", 20'h01200, 20'h99999, 1'b0);
    look("R4", 20'h00D00, 1'b0);
    fill("R7", 20'h01300, 20'hAAAAA, 1'b0);
    look("R4", 20'h00E00, 1'b0);
    look("R4", 20'h01200, 1'b0);

    // R8: invalidate absent page, then a dirty one
    cyc("R8", 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, 20'h0FFFF, 1'b0);
    look("R8", 20'h00A00, 1'b0);
    cyc("R8", 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, 20'h00A00, 1'b0);
    look("R8", 20'h00A00, 1'b0);

    // R11: invalidate beats fill; write hit during invalidate leaves dirty clear
    cyc("R11", 1'b0, 1'b0, '0, '0, 1'b1, 20'h01400, 20'hBBBBB, 2'd1, 1'b0, 1'b1, 20'h00B00, 1'b0);
    look("R11", 20'h01400, 1'b0);
    cyc("R11", 1'b1, 1'b1, 20'h00C00, 12'h001, 1'b0, '0, '0, '0, 1'b0, 1'b1, 20'h0EEEE, 1'b0);
    look("R11", 20'h00C00, 1'b0);

    // R10, R9: flush with lookup and fill in the same cycle, then drain
    look("R9", 20'h00F00, 1'b1);
    cyc("R10", 1'b1, 1'b0, 20'h00C00, 12'h3, 1'b1, 20'h01500, 20'hCCCCC, 2'd2, 1'b1, 1'b0, '0, 1'b1);
    for (int k = 0; k < N + 2; k++) look("R9", 20'h00F00, 1'b0);
    look("R10", 20'h01500, 1'b0);

    // R5: random policy
    for (int k = 0; k < N; k++) rcyc(1'b0, '0, 1'b1, 20'h00100 + 20'(k), 1'b0, '0);
    rcyc(1'b0, '0, 1'b1, 20'h00108, 1'b0, '0);
    hits = 0;
    for (int k = 0; k <= N; k++) begin
      rcyc(1'b1, 20'h00100 + 20'(k), 1'b0, '0, 1'b0, '0);
      if (r_hit) hits++;
      if (k == N) check(r_hit && r_pfn == (20'h00108 ^ 20'h5A5A5), "R5", "new entry hit",
                        {43'd0, r_hit, r_pfn}, {43'd0, 1'b1, 20'h00108 ^ 20'h5A5A5});
    end
    check(hits == N, "R5", "resident count after eviction", 64'(hits), 64'(N));
    rcyc(1'b0, '0, 1'b0, '0, 1'b1, 20'h00108);
    rcyc(1'b0, '0, 1'b1, 20'h00109, 1'b0, '0);
    hits = 0;
    for (int k = 0; k <= N + 1; k++) begin
      rcyc(1'b1, 20'h00100 + 20'(k), 1'b0, '0, 1'b0, '0);
      if (r_hit) hits++;
    end
    check(hits == N, "R5", "free slot used, nothing displaced", 64'(hits), 64'(N));
    check(r_wb_en == 1'b0, "R7", "clean random evictions no write-back", 64'(r_wb_en), 64'd0);
    rcyc(1'b0, '0, 1'b0, '0, 1'b0, '0);

    // constrained random on the LRU instance
    cool = 0;
    for (int k = 0; k < 1500; k++) begin
      r  = $urandom_range(0, 99);
      fl = (cool == 0) && (r < 2);
      ie = !fl && r >= 2 && r < 10;
      iv = pool($urandom_range(0, 15));
      fv = pool($urandom_range(0, 15));
      fe = (cool == 0) && r >= 10 && r < 35 && find(fv) < 0;
      le = ($urandom_range(0, 3) != 0);
      we = ($urandom_range(0, 2) == 0);
      lv = pool($urandom_range(0, 15));
      cyc(fl ? "R9" : ie ? "R8" : fe ? "R3" : we ? "R6" : "R1", le, we, lv,
          12'($urandom), fe, fv, 20'($urandom), 2'($urandom), 1'($urandom),
          ie, iv, fl);
      if (fl) cool = N + 2;
      else if (cool > 0) cool--;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule